// File: doc/BRIEF.md
# Three-Dimensional DMA Transfer Sequencer

This block walks a DMA transfer that is laid out in three levels: arrays of ACNT bytes, frames of BCNT arrays and blocks of CCNT frames. Descriptors sit in a small on-chip descriptor RAM that is written one 32-bit word at a time. An `arm` pulse copies one descriptor into the block's working copy. After that, every trigger moves the transfer on by one sync element. A trigger can come from a hardware event, a software request or a chain input. For each element the block issues one or more transfer requests (source address, destination address, byte count) to a data mover outside the block. It also raises completion and chain pulses that carry a completion code.

Each dimension has its own signed stride, kept separately for source and destination. Either side can be held at a constant address, which suits a FIFO port. A trigger moves either one array or one whole frame, depending on the sync mode. The middle count is refilled from a reload field at every frame boundary. When the last element is done, the working copy is refilled from the linked descriptor. A null link empties the working copy instead. A static descriptor is never advanced or relinked.

Top module: `dma3d_seq`

## Requirements
- R1: After reset `busy`, `req_valid`, `tc_done`, `tc_final`, `tc_irq`, `tc_chain` and `err_null` are low, and the working copy holds zero counts.
- R2: Descriptor word k (0..7) of slot i is written through `cfg_we`/`cfg_idx`/`cfg_word`/`cfg_data`. The words are, in order:
  - word 0: options.
  - word 1: source address.
  - word 2: {BCNT[31:16], ACNT[15:0]}.
  - word 3: destination address.
  - word 4: {dst B-stride, src B-stride}.
  - word 5: {BCNT reload[31:16], link[15:0]}.
  - word 6: {dst C-stride, src C-stride}.
  - word 7: CCNT[15:0].

  An `arm` pulse in idle loads slot `arm_idx`. The first element then starts at the loaded source and destination addresses, and `req_bytes` equals ACNT.
- R3: With option bit 2 clear (array sync), each trigger issues exactly one request. Inside a frame, each side moves by its sign-extended 16-bit B-stride after each array.
- R4: In array sync, after the last array of a frame, each side moves to its frame start plus its signed C-stride. BCNT is refilled from the reload field, so the next frame has reload-count arrays.
- R5: With option bit 2 set (frame sync), one trigger issues BCNT requests on consecutive cycles. The addresses step by the B-stride, and the next frame starts at the previous frame start plus the C-stride.
- R6: Option bit 0 (source) and bit 1 (destination) hold that side's address constant, whatever its strides are.
- R7: `tc_done` pulses with the last request of every element. For a non-final element, `tc_irq` follows option bit 21, `tc_chain` follows option bit 23, and `tc_final` stays low.
- R8: For the final element, `tc_final` pulses once. `tc_irq` follows option bit 20, `tc_chain` follows option bit 22, and `tc_code` equals option bits 17:12.
- R9: After the final element with link not 0xFFFF, `busy` stays high while slot link[IW-1:0] is fetched. The next trigger then follows the new descriptor.
- R10: After the final element with link 0xFFFF, the counts are zero. Any trigger on a zero count pulses `err_null` for one cycle and issues no request.
- R11: With option bit 3 set, the working copy is not advanced or relinked, so every trigger repeats the same element.
- R12: A trigger that arrives while `busy` is high is dropped. Each of `trig_hw`, `trig_sw` and `trig_chain` starts an element by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor RAM word write enable |
| cfg_idx | input | IW | Descriptor slot written |
| cfg_word | input | 3 | Word within the slot |
| cfg_data | input | 32 | Word value |
| arm | input | 1 | Load slot `arm_idx` into the working copy |
| arm_idx | input | IW | Slot to load |
| trig_hw | input | 1 | Hardware event trigger |
| trig_sw | input | 1 | Software trigger |
| trig_chain | input | 1 | Chain trigger |
| busy | output | 1 | Element in progress or descriptor fetch |
| req_valid | output | 1 | Transfer request strobe |
| req_src | output | 32 | Request source address |
| req_dst | output | 32 | Request destination address |
| req_bytes | output | 16 | Request byte count |
| tc_done | output | 1 | Element finished |
| tc_final | output | 1 | Last element of the descriptor |
| tc_irq | output | 1 | Completion interrupt pulse |
| tc_chain | output | 1 | Chain trigger pulse |
| tc_code | output | 6 | Completion code |
| err_null | output | 1 | Trigger on an empty working copy |

## Verification
The bench builds the block with `N_DESC` = 8, which gives a 3-bit slot index. A link value of 0xFFFF, which is wider than that index, must still be treated as null, and a link to slot 1 must be truncated correctly. The bench uses four slots. Together they cover both sync modes, signed negative strides, a reload count that differs from BCNT, a constant destination, a static descriptor, and a chain from one slot to a frame-sync slot that ends in a null link.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 16;
  localparam int CODE_W  = 6;
  localparam int N_WORDS = 8;
  localparam int ROW_W   = WORD_W * N_WORDS;

  localparam int OPT_SFIFO   = 0;
  localparam int OPT_DFIFO   = 1;
  localparam int OPT_FRAME   = 2;
  localparam int OPT_STATIC  = 3;
  localparam int OPT_CODE_LO = 12;
  localparam int OPT_FIN_IRQ = 20;
  localparam int OPT_MID_IRQ = 21;
  localparam int OPT_FIN_CHN = 22;
  localparam int OPT_MID_CHN = 23;

  localparam logic [CNT_W-1:0] NULL_LINK = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FETCH, ST_LOAD} seq_st_t;

  typedef struct packed {
    logic              sfifo;
    logic              dfifo;
    logic              frame_sync;
    logic              stat;
    logic [CODE_W-1:0] code;
    logic              fin_irq;
    logic              mid_irq;
    logic              fin_chn;
    logic              mid_chn;
    logic [CNT_W-1:0]  acnt;
    logic [CNT_W-1:0]  bcnt;
    logic [CNT_W-1:0]  ccnt;
    logic [CNT_W-1:0]  brld;
    logic [CNT_W-1:0]  link;
    logic [CNT_W-1:0]  sbidx;
    logic [CNT_W-1:0]  dbidx;
    logic [CNT_W-1:0]  scidx;
    logic [CNT_W-1:0]  dcidx;
  } work_t;
endpackage

// File: rtl/dma3d_desc_ram.sv
module dma3d_desc_ram
  import dma3d_pkg::*;
#(
  parameter int N_DESC = 16,
  localparam int IW = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     waddr,
  input  logic [2:0]        wword,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IW-1:0]     raddr,
  output logic [ROW_W-1:0]  rdata
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
    logic [WORD_W-1:0] mem [N_DESC];
    logic [WORD_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && wword == 3'(g)) mem[waddr] <= wdata;
      rd_q <= mem[raddr];
    end
    assign rdata[g*WORD_W +: WORD_W] = rd_q;
  end
endmodule

// File: rtl/dma3d_addr_step.sv
module dma3d_addr_step
  import dma3d_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [CNT_W-1:0]  stride,
  input  logic              hold,
  output logic [WORD_W-1:0] nxt
);
  always_comb begin
    if (hold) nxt = base;
    else      nxt = base + {{(WORD_W-CNT_W){stride[CNT_W-1]}}, stride};
  end
endmodule

// File: rtl/dma3d_evt.sv
module dma3d_evt
  import dma3d_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              last,
  input  logic [CODE_W-1:0] code_in,
  input  logic              fin_irq,
  input  logic              mid_irq,
  input  logic              fin_chn,
  input  logic              mid_chn,
  output logic              tc_done,
  output logic              tc_final,
  output logic              tc_irq,
  output logic              tc_chain,
  output logic [CODE_W-1:0] tc_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_done  <= 1'b0;
      tc_final <= 1'b0;
      tc_irq   <= 1'b0;
      tc_chain <= 1'b0;
      tc_code  <= '0;
    end else begin
      tc_done  <= fire;
      tc_final <= fire & last;
      tc_irq   <= fire & (last ? fin_irq : mid_irq);
      tc_chain <= fire & (last ? fin_chn : mid_chn);
      tc_code  <= fire ? code_in : '0;
    end
  end
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int N_DESC = 16,
  localparam int IW = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [2:0]        cfg_word,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              arm,
  input  logic [IW-1:0]     arm_idx,
  input  logic              trig_hw,
  input  logic              trig_sw,
  input  logic              trig_chain,
  output logic              busy,
  output logic              req_valid,
  output logic [WORD_W-1:0] req_src,
  output logic [WORD_W-1:0] req_dst,
  output logic [CNT_W-1:0]  req_bytes,
  output logic              tc_done,
  output logic              tc_final,
  output logic              tc_irq,
  output logic              tc_chain,
  output logic [CODE_W-1:0] tc_code,
  output logic              err_null
);
  seq_st_t           st;
  work_t             w, nd;
  logic [WORD_W-1:0] csrc, cdst, fsrc, fdst;
  logic [WORD_W-1:0] nd_src, nd_dst;
  logic [WORD_W-1:0] csrc_nb, cdst_nb, fsrc_nc, fdst_nc;
  logic [CNT_W-1:0]  left;
  logic [IW-1:0]     fetch_idx;
  logic [ROW_W-1:0]  row;
  logic              unused_row_bits;

  logic trig_any, empty, last_arr, frame_end, final_el, fire;

  // descriptor storage, one lane per word
  dma3d_desc_ram #(.N_DESC(N_DESC)) u_ram (
    .clk(clk), .we(cfg_we), .waddr(cfg_idx), .wword(cfg_word),
    .wdata(cfg_data), .raddr(fetch_idx), .rdata(row)
  );

  // decode of a fetched row into the working-copy layout
  always_comb begin
    nd            = '0;
    nd.sfifo      = row[OPT_SFIFO];
    nd.dfifo      = row[OPT_DFIFO];
    nd.frame_sync = row[OPT_FRAME];
    nd.stat       = row[OPT_STATIC];
    nd.code       = row[OPT_CODE_LO +: CODE_W];
    nd.fin_irq    = row[OPT_FIN_IRQ];
    nd.mid_irq    = row[OPT_MID_IRQ];
    nd.fin_chn    = row[OPT_FIN_CHN];
    nd.mid_chn    = row[OPT_MID_CHN];
    nd.acnt       = row[2*WORD_W +: CNT_W];
    nd.bcnt       = row[2*WORD_W+CNT_W +: CNT_W];
    nd.sbidx      = row[4*WORD_W +: CNT_W];
    nd.dbidx      = row[4*WORD_W+CNT_W +: CNT_W];
    nd.link       = row[5*WORD_W +: CNT_W];
    nd.brld       = row[5*WORD_W+CNT_W +: CNT_W];
    nd.scidx      = row[6*WORD_W +: CNT_W];
    nd.dcidx      = row[6*WORD_W+CNT_W +: CNT_W];
    nd.ccnt       = row[7*WORD_W +: CNT_W];
  end
  assign nd_src = row[1*WORD_W +: WORD_W];
  assign nd_dst = row[3*WORD_W +: WORD_W];
  assign unused_row_bits = ^{row[11:4], row[31:24], row[8*WORD_W-1:7*WORD_W+CNT_W]};

  // address arithmetic: array step from cursor, frame step from frame start
  dma3d_addr_step u_sb (.base(csrc), .stride(w.sbidx), .hold(w.sfifo), .nxt(csrc_nb));
  dma3d_addr_step u_db (.base(cdst), .stride(w.dbidx), .hold(w.dfifo), .nxt(cdst_nb));
  dma3d_addr_step u_sc (.base(fsrc), .stride(w.scidx), .hold(w.sfifo), .nxt(fsrc_nc));
  dma3d_addr_step u_dc (.base(fdst), .stride(w.dcidx), .hold(w.dfifo), .nxt(fdst_nc));

  assign trig_any  = trig_hw | trig_sw | trig_chain;
  assign empty     = (w.acnt == '0) || (w.bcnt == '0) || (w.ccnt == '0);
  assign last_arr  = (left == CNT_W'(1));
  assign frame_end = w.frame_sync ? last_arr : (w.bcnt == CNT_W'(1));
  assign final_el  = frame_end && (w.ccnt == CNT_W'(1));
  assign fire      = (st == ST_XFER) && last_arr;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      w         <= '0;
      csrc      <= '0;
      cdst      <= '0;
      fsrc      <= '0;
      fdst      <= '0;
      left      <= '0;
      fetch_idx <= '0;
      req_valid <= 1'b0;
      req_src   <= '0;
      req_dst   <= '0;
      req_bytes <= '0;
      err_null  <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      err_null  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (arm) begin
            fetch_idx <= arm_idx;
            st        <= ST_FETCH;
          end else if (trig_any) begin
            if (empty) err_null <= 1'b1;
            else begin
              st   <= ST_XFER;
              left <= w.frame_sync ? w.bcnt : CNT_W'(1);
            end
          end
        end
        ST_XFER: begin
          req_valid <= 1'b1;
          req_src   <= csrc;
          req_dst   <= cdst;
          req_bytes <= w.acnt;
          if (!last_arr) begin
            csrc <= csrc_nb;
            cdst <= cdst_nb;
            left <= left - CNT_W'(1);
          end else begin
            st <= ST_IDLE;
            if (w.stat) begin
              csrc <= fsrc;
              cdst <= fdst;
            end else if (final_el) begin
              if (w.link == NULL_LINK) begin
                w.acnt <= '0;
                w.bcnt <= '0;
                w.ccnt <= '0;
              end else begin
                fetch_idx <= w.link[IW-1:0];
                st        <= ST_FETCH;
              end
            end else if (frame_end) begin
              fsrc   <= fsrc_nc;
              csrc   <= fsrc_nc;
              fdst   <= fdst_nc;
              cdst   <= fdst_nc;
              w.bcnt <= w.brld;
              w.ccnt <= w.ccnt - CNT_W'(1);
            end else begin
              csrc   <= csrc_nb;
              cdst   <= cdst_nb;
              w.bcnt <= w.bcnt - CNT_W'(1);
            end
          end
        end
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          w    <= nd;
          csrc <= nd_src;
          fsrc <= nd_src;
          cdst <= nd_dst;
          fdst <= nd_dst;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  dma3d_evt u_evt (
    .clk(clk), .rst(rst), .fire(fire), .last(final_el), .code_in(w.code),
    .fin_irq(w.fin_irq), .mid_irq(w.mid_irq), .fin_chn(w.fin_chn), .mid_chn(w.mid_chn),
    .tc_done(tc_done), .tc_final(tc_final), .tc_irq(tc_irq),
    .tc_chain(tc_chain), .tc_code(tc_code)
  );
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        req_valid,
  input logic        tc_done,
  input logic        tc_final,
  input logic        tc_irq,
  input logic        err_null,
  input logic        mid_irq,
  input logic        fin_irq,
  input logic        stat,
  input logic        frame_sync,
  input logic [31:0] cur_src
);
  a_r12_req_needs_busy: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(busy));
  a_r10_err_without_req: assert property (@(posedge clk) disable iff (rst)
    err_null |-> !req_valid);
  a_r7_done_with_req: assert property (@(posedge clk) disable iff (rst)
    tc_done |-> req_valid);
  a_r8_final_with_done: assert property (@(posedge clk) disable iff (rst)
    tc_final |-> tc_done);
  a_r7_mid_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    (tc_irq && !tc_final) |-> mid_irq);
  a_r8_fin_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    (tc_irq && tc_final) |-> fin_irq);
  a_r11_static_holds_src: assert property (@(posedge clk) disable iff (rst)
    (tc_done && stat && !frame_sync) |-> $stable(cur_src));
endmodule

bind dma3d_seq dma3d_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid),
  .tc_done(tc_done), .tc_final(tc_final), .tc_irq(tc_irq), .err_null(err_null),
  .mid_irq(w.mid_irq), .fin_irq(w.fin_irq), .stat(w.stat),
  .frame_sync(w.frame_sync), .cur_src(csrc)
);

// File: tb/dma3d_seq_bench.sv
module dma3d_seq_bench;
  localparam int ND = 8;
  localparam int IW = $clog2(ND);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0; logic [IW-1:0] cfg_idx = '0; logic [2:0] cfg_word = '0;
  logic [31:0] cfg_data = '0;
  logic arm = 1'b0; logic [IW-1:0] arm_idx = '0;
  logic trig_hw = 1'b0, trig_sw = 1'b0, trig_chain = 1'b0;
  logic busy, req_valid, tc_done, tc_final, tc_irq, tc_chain, err_null;
  logic [31:0] req_src, req_dst; logic [15:0] req_bytes; logic [5:0] tc_code;

  always #5 clk = ~clk;

  dma3d_seq #(.N_DESC(ND)) u_dma3d_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
    .cfg_data(cfg_data), .arm(arm), .arm_idx(arm_idx), .trig_hw(trig_hw),
    .trig_sw(trig_sw), .trig_chain(trig_chain), .busy(busy), .req_valid(req_valid),
    .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes), .tc_done(tc_done),
    .tc_final(tc_final), .tc_irq(tc_irq), .tc_chain(tc_chain), .tc_code(tc_code),
    .err_null(err_null)
  );

  // request/event log sampled on falling edges
  logic [31:0] lg_src [64]; logic [31:0] lg_dst [64]; logic [15:0] lg_bytes [64];
  logic lg_done [64]; logic lg_fin [64]; logic lg_irq [64]; logic lg_chn [64];
  logic [5:0] lg_code [64];
  int n_req = 0, n_err = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid && n_req < 64) begin
        lg_src[n_req] <= req_src; lg_dst[n_req] <= req_dst; lg_bytes[n_req] <= req_bytes;
        lg_done[n_req] <= tc_done; lg_fin[n_req] <= tc_final; lg_irq[n_req] <= tc_irq;
        lg_chn[n_req] <= tc_chain; lg_code[n_req] <= tc_code;
        n_req <= n_req + 1;
      end
      if (err_null) n_err <= n_err + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_desc(input int idx, input logic [31:0] w0, w1, w2, w3, w4, w5, w6, w7);
    logic [31:0] wv [8];
    wv = '{w0, w1, w2, w3, w4, w5, w6, w7};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_word = 3'(k); cfg_data = wv[k];
    end
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_arm(input int idx);
    @(negedge clk); arm = 1'b1; arm_idx = IW'(idx);
    @(negedge clk); arm = 1'b0;
    settle();
  endtask

  // kind 0 hw, 1 sw, 2 chain; poke: extra trigger while busy
  task automatic fire(input int kind, input bit poke);
    @(negedge clk);
    trig_hw = (kind == 0); trig_sw = (kind == 1); trig_chain = (kind == 2);
    @(negedge clk);
    trig_hw = 1'b0; trig_sw = 1'b0; trig_chain = 1'b0;
    if (poke) begin
      @(negedge clk); trig_sw = 1'b1;
      @(negedge clk); trig_sw = 1'b0;
    end
    settle();
  endtask

  task automatic t_reset();
    int e0, r0;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 events", 32'({tc_done, tc_final, tc_irq, tc_chain}), 0);
    chk("R1 err_null", 32'(err_null), 0);
    e0 = n_err; r0 = n_req;
    fire(0, 1'b0);
    chk("R1 R10 empty trigger err", 32'(n_err - e0), 1);
    chk("R1 R10 empty trigger no req", 32'(n_req - r0), 0);
  endtask

  // array sync, negative destination strides, linked to slot 1
  task automatic t_array_sync();
    int b0;
    wr_desc(0, 32'h0070_5000, 32'h0000_1000, {16'd3, 16'd4}, 32'h0000_2000,
            {16'hFFF8, 16'h0010}, {16'd3, 16'd1}, {16'hFFC0, 16'h0100}, 32'd2);
    wr_desc(1, 32'h0082_A006, 32'h0000_4000, {16'd4, 16'd8}, 32'h0000_9000,
            {16'h0004, 16'h0020}, {16'd4, 16'hFFFF}, {16'h0010, 16'h0200}, 32'd2);
    do_arm(0);
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 3; b++) begin
        int e; bit fin;
        e = c * 3 + b; fin = (e == 5);
        b0 = n_req;
        fire(e % 3, 1'b0);
        chk("R3 R12 one req per trigger", 32'(n_req - b0), 1);
        chk("R2 R3 R4 src", lg_src[b0], 32'(32'h1000 + c * 32'h100 + b * 32'h10));
        chk("R3 R4 dst", lg_dst[b0], 32'(32'h2000 - c * 32'h40 - b * 8));
        chk("R2 bytes", 32'(lg_bytes[b0]), 4);
        chk("R7 done", 32'(lg_done[b0]), 1);
        chk("R7 R8 final", 32'(lg_fin[b0]), 32'(fin));
        chk("R7 R8 irq", 32'(lg_irq[b0]), 1);
        chk("R7 R8 chain", 32'(lg_chn[b0]), 32'(fin));
        if (fin) chk("R8 code", 32'(lg_code[b0]), 5);
      end
    end
  endtask

  // frame sync from linked slot 1: constant dst, then null link
  task automatic t_frame_sync();
    int b0, e0;
    for (int c = 0; c < 2; c++) begin
      b0 = n_req;
      fire(1, c == 0);
      chk("R5 R12 reqs per trigger", 32'(n_req - b0), 4);
      for (int a = 0; a < 4; a++) begin
        bit lastp;
        lastp = (a == 3);
        chk("R5 R9 src", lg_src[b0 + a], 32'(32'h4000 + c * 32'h200 + a * 32'h20));
        chk("R6 fifo dst", lg_dst[b0 + a], 32'h9000);
        chk("R5 bytes", 32'(lg_bytes[b0 + a]), 8);
        chk("R7 done on last array", 32'(lg_done[b0 + a]), 32'(lastp));
        chk("R7 mid chain", 32'(lg_chn[b0 + a]), 32'(lastp && c == 0));
        chk("R8 final", 32'(lg_fin[b0 + a]), 32'(lastp && c == 1));
        chk("R8 irq off", 32'(lg_irq[b0 + a]), 0);
      end
      if (c == 1) chk("R8 code", 32'(lg_code[b0 + 3]), 32'h2A);
    end
    e0 = n_err; b0 = n_req;
    fire(2, 1'b0);
    chk("R10 null link err", 32'(n_err - e0), 1);
    chk("R10 null link no req", 32'(n_req - b0), 0);
  endtask

  // reload count differs from BCNT
  task automatic t_reload();
    int b0, e0;
    logic [31:0] exp_src [5];
    exp_src = '{32'h0, 32'h1, 32'h10, 32'h11, 32'h12};
    wr_desc(2, 32'h0, 32'h0, {16'd2, 16'd2}, 32'h100,
            {16'h0, 16'h1}, {16'd3, 16'hFFFF}, {16'h0, 16'h10}, 32'd2);
    do_arm(2);
    for (int e = 0; e < 5; e++) begin
      b0 = n_req;
      fire(0, 1'b0);
      chk("R4 reload src", lg_src[b0], exp_src[e]);
      chk("R4 final on 5th", 32'(lg_fin[b0]), 32'(e == 4));
      chk("R7 irq disabled", 32'(lg_irq[b0]), 0);
    end
    e0 = n_err;
    fire(1, 1'b0);
    chk("R10 after reload run", 32'(n_err - e0), 1);
  endtask

  task automatic t_static();
    int b0;
    wr_desc(3, 32'h0020_0008, 32'h500, {16'd2, 16'd16}, 32'h600,
            {16'h4, 16'h4}, {16'd2, 16'd0}, {16'h40, 16'h40}, 32'd1);
    do_arm(3);
    for (int k = 0; k < 3; k++) begin
      b0 = n_req;
      fire(k, 1'b0);
      chk("R11 static src", lg_src[b0], 32'h500);
      chk("R11 static dst", lg_dst[b0], 32'h600);
      chk("R11 static not final", 32'(lg_fin[b0]), 0);
      chk("R11 static mid irq", 32'(lg_irq[b0]), 1);
    end
  endtask

  bit timed_out = 1'b0;
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_array_sync();
        t_frame_sync();
        t_reload();
        t_static();
      end
      begin
        repeat (200000) @(negedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_fail);
    $finish;
  end
endmodule